// File: doc/BRIEF.md
# Dual-Issue In-Order Instruction Dispatcher

This block takes pre-decoded instructions from a fetch side, holds them in a small circular queue, and sends them to one integer unit and one floating-point unit. In every cycle it looks at the two oldest queued instructions. The oldest one is always offered to the unit that matches its class. The second-oldest goes out in the same cycle only under three conditions: the two instructions belong to different classes, no register conflict exists between them, and the oldest one is actually accepted.

The conflict comparison between the two candidates is made on every cycle, whatever the contents of the stream. A pair that cannot leave together is split. The older instruction leaves alone, and the younger one becomes the head on the next cycle, so program order is kept. Each instruction carries a class bit, a destination register, two source registers and an opaque payload. The payload reaches the unit unchanged.

Top module: `dual_issue_dispatch`

## Requirements
- R1: After reset the queue is empty, `intValid` and `fpValid` are low and `pushNotFull` is high.
- R2: Instructions reach the units in the order they were pushed. At most two leave per cycle, and a younger one never leaves before an older one.
- R3: When the two oldest instructions share a class (class bit 0 = integer, 1 = floating point), only the oldest is offered, on its own unit.
- R4: A younger instruction whose source register equals the older one's destination is not paired with it.
- R5: A younger instruction whose destination equals either source of the older one is not paired with it.
- R6: Two instructions with the same destination register are not paired.
- R7: An integer and a floating-point instruction with all registers distinct are offered together on both units in the same cycle.
- R8: When the oldest instruction's unit is not ready, the younger instruction is not offered, even if it is independent.
- R9: `pushNotFull` is low while DEPTH entries are held, and a push in that state is ignored.
- R10: While `flush` is high no valid is raised. After that edge the queue is empty and pushes made during the flush are dropped.
- R11: The destination, source and payload fields appear on the unit's outputs exactly as they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discards every queued entry |
| pushValid | input | 1 | Fetch side offers an instruction |
| pushIsFp | input | 1 | Class of pushed instruction, 1 = floating point |
| pushDst | input | 5 | Destination register |
| pushSrcA | input | 5 | First source register |
| pushSrcB | input | 5 | Second source register |
| pushPayload | input | 16 | Opaque payload |
| pushNotFull | output | 1 | Queue can take a push |
| intValid | output | 1 | Instruction offered to integer unit |
| intReady | input | 1 | Integer unit accepts |
| intDst | output | 5 | Destination to integer unit |
| intSrcA | output | 5 | First source to integer unit |
| intSrcB | output | 5 | Second source to integer unit |
| intPayload | output | 16 | Payload to integer unit |
| fpValid | output | 1 | Instruction offered to floating-point unit |
| fpReady | input | 1 | Floating-point unit accepts |
| fpDst | output | 5 | Destination to floating-point unit |
| fpSrcA | output | 5 | First source to floating-point unit |
| fpSrcB | output | 5 | Second source to floating-point unit |
| fpPayload | output | 16 | Payload to floating-point unit |

## Verification
The hardest case to reach is a mixed-class pair whose only defect is one specific register conflict, or whose older member waits on a unit that is not ready. With 32 registers, random traffic almost never produces such pairs. The stimulus therefore draws register numbers from a range of four for most of the run, so RAW, WAR and WAW collisions occur often. It also drops each unit's ready on its own, at random, so the cases where a younger instruction is held back by its elder come up repeatedly. Directed phases fill the queue while both units are stalled, and then flush it.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  parameter int REG_W = 5;
  parameter int PAY_W = 16;

  typedef struct packed {
    logic             isFp;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
    logic [PAY_W-1:0] payload;
  } instr_t;

  // strobes from control to queue datapath
  typedef struct packed {
    logic       push;
    logic       flush;
    logic [1:0] popCnt;
  } qStrobe_t;
endpackage

// File: rtl/dispatch_queue.sv
module dispatch_queue
  import dispatch_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  qStrobe_t strb,
  input  instr_t   pushData,
  output instr_t   head,
  output instr_t   next,
  output logic     haveOne,
  output logic     haveTwo,
  output logic     notFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  instr_t            mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      rdPtr <= rdPtr + PTR_W'(strb.popCnt);
      wrPtr <= wrPtr + PTR_W'(strb.push);
      count <= count + CNT_W'(strb.push) - CNT_W'(strb.popCnt);
    end
  end

  assign head    = mem[rdPtr];
  assign next    = mem[rdPtr + PTR_W'(1)];
  assign haveOne = (count != '0);
  assign haveTwo = (count > CNT_W'(1));
  assign notFull = (count != CNT_W'(DEPTH));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(strb.popCnt) <= count);
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.flush |=> !haveOne);
endmodule

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     pushValid,
  input  logic     notFull,
  input  logic     haveOne,
  input  logic     haveTwo,
  input  instr_t   head,
  input  instr_t   next,
  input  logic     intReady,
  input  logic     fpReady,
  output logic     intValid,
  output logic     fpValid,
  output instr_t   intInstr,
  output instr_t   fpInstr,
  output qStrobe_t strb
);
  logic rawHaz, warHaz, wawHaz, mixed, headReady, nextReady;
  logic headOffer, pairOffer, headFire, pairFire;

  // checked every cycle between the two oldest entries
  assign rawHaz = (next.srcA == head.dst) || (next.srcB == head.dst);
  assign warHaz = (next.dst == head.srcA) || (next.dst == head.srcB);
  assign wawHaz = (next.dst == head.dst);
  assign mixed  = (head.isFp != next.isFp);

  assign headReady = head.isFp ? fpReady : intReady;
  assign nextReady = next.isFp ? fpReady : intReady;

  assign headOffer = haveOne && !flush;
  assign pairOffer = haveTwo && !flush && mixed && headReady
                     && !rawHaz && !warHaz && !wawHaz;

  assign intValid = (headOffer && !head.isFp) || (pairOffer && !next.isFp);
  assign fpValid  = (headOffer &&  head.isFp) || (pairOffer &&  next.isFp);
  assign intInstr = head.isFp ? next : head;
  assign fpInstr  = head.isFp ? head : next;

  assign headFire    = headOffer && headReady;
  assign pairFire    = pairOffer && nextReady;
  assign strb.popCnt = 2'(headFire) + 2'(pairFire);
  assign strb.push   = pushValid && notFull && !flush;
  assign strb.flush  = flush;

  p_pair_waits_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (intValid && fpValid) |-> (head.isFp ? fpReady : intReady));
  p_pair_distinct_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (intValid && fpValid) |-> (intInstr.dst != fpInstr.dst));
endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
  import dispatch_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             pushValid,
  input  logic             pushIsFp,
  input  logic [REG_W-1:0] pushDst,
  input  logic [REG_W-1:0] pushSrcA,
  input  logic [REG_W-1:0] pushSrcB,
  input  logic [PAY_W-1:0] pushPayload,
  output logic             pushNotFull,
  output logic             intValid,
  input  logic             intReady,
  output logic [REG_W-1:0] intDst,
  output logic [REG_W-1:0] intSrcA,
  output logic [REG_W-1:0] intSrcB,
  output logic [PAY_W-1:0] intPayload,
  output logic             fpValid,
  input  logic             fpReady,
  output logic [REG_W-1:0] fpDst,
  output logic [REG_W-1:0] fpSrcA,
  output logic [REG_W-1:0] fpSrcB,
  output logic [PAY_W-1:0] fpPayload
);
  qStrobe_t strb;
  instr_t   pushData, head, next, intInstr, fpInstr;
  logic     haveOne, haveTwo;

  assign pushData = '{isFp: pushIsFp, dst: pushDst, srcA: pushSrcA,
                      srcB: pushSrcB, payload: pushPayload};

  dispatch_queue #(.DEPTH(DEPTH)) uQueue (
    .clk(clk), .rst_n(rst_n), .strb(strb), .pushData(pushData),
    .head(head), .next(next), .haveOne(haveOne), .haveTwo(haveTwo),
    .notFull(pushNotFull)
  );

  dispatch_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pushValid(pushValid),
    .notFull(pushNotFull), .haveOne(haveOne), .haveTwo(haveTwo),
    .head(head), .next(next), .intReady(intReady), .fpReady(fpReady),
    .intValid(intValid), .fpValid(fpValid), .intInstr(intInstr),
    .fpInstr(fpInstr), .strb(strb)
  );

  assign intDst     = intInstr.dst;
  assign intSrcA    = intInstr.srcA;
  assign intSrcB    = intInstr.srcB;
  assign intPayload = intInstr.payload;
  assign fpDst      = fpInstr.dst;
  assign fpSrcA     = fpInstr.srcA;
  assign fpSrcB     = fpInstr.srcB;
  assign fpPayload  = fpInstr.payload;
endmodule

// File: tb/dual_issue_dispatch_test.sv
`timescale 1ns/1ps
module dual_issue_dispatch_test;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0, flush = 0, pushValid = 0, pushIsFp = 0;
  logic [4:0] pushDst = 0, pushSrcA = 0, pushSrcB = 0;
  logic [15:0] pushPayload = 0;
  logic pushNotFull, intValid, fpValid, intReady = 0, fpReady = 0;
  logic [4:0] intDst, intSrcA, intSrcB, fpDst, fpSrcA, fpSrcB;
  logic [15:0] intPayload, fpPayload;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mq[$];  // model queue: [31] fp, [30:26] dst, [25:21] srcA, [20:16] srcB, [15:0] payload

  always #2 clk = ~clk;

  dual_issue_dispatch #(.DEPTH(DEPTH)) uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string pairTag(input logic [31:0] h, input logic [31:0] n);
    if (h[31] == n[31]) return "R3";
    if (n[25:21] == h[30:26] || n[20:16] == h[30:26]) return "R4";
    if (n[30:26] == h[25:21] || n[30:26] == h[20:16]) return "R5";
    if (n[30:26] == h[30:26]) return "R6";
    return "R7";
  endfunction

  task automatic cycle(input logic pv, input logic fl, input logic ir,
                       input logic fr, input logic [31:0] w);
    int n, pops;
    logic eInt, eFp, hr;
    logic [31:0] intE, fpE, h, nx;
    string tag;
    @(negedge clk);
    pushValid = pv; flush = fl; intReady = ir; fpReady = fr;
    {pushIsFp, pushDst, pushSrcA, pushSrcB, pushPayload} = w;
    #1;
    n = mq.size(); eInt = 0; eFp = 0; intE = 0; fpE = 0; tag = "R2";
    if (fl) tag = "R10";
    else if (n >= 1) begin
      h = mq[0];
      hr = h[31] ? fr : ir;
      if (h[31]) begin eFp = 1; fpE = h; end else begin eInt = 1; intE = h; end
      if (n >= 2) begin
        nx = mq[1];
        tag = hr ? pairTag(h, nx) : "R8";
        if (hr && tag == "R7") begin
          if (nx[31]) begin eFp = 1; fpE = nx; end else begin eInt = 1; intE = nx; end
        end
      end
    end
    chk({tag, " intValid"}, 64'(intValid), 64'(eInt));
    chk({tag, " fpValid"}, 64'(fpValid), 64'(eFp));
    chk("R9 notFull", 64'(pushNotFull), 64'(n < DEPTH));
    if (eInt) chk("R11 int fields", 64'({intDst, intSrcA, intSrcB, intPayload}), 64'(intE[30:0]));
    if (eFp)  chk("R11 fp fields", 64'({fpDst, fpSrcA, fpSrcB, fpPayload}), 64'(fpE[30:0]));
    pops = int'(eInt && ir) + int'(eFp && fr);
    @(posedge clk);
    if (fl) mq.delete();
    else begin
      for (int i = 0; i < pops; i++) void'(mq.pop_front());
      if (pv && n < DEPTH) mq.push_back(w);
    end
  endtask

  function automatic logic [31:0] mk(input logic fp, input int d, input int a, input int b);
    return {fp, 5'(d), 5'(a), 5'(b), 16'($urandom)};
  endfunction

  function automatic logic [31:0] rnd(input int span);
    return {1'($urandom), 5'($urandom % span), 5'($urandom % span),
            5'($urandom % span), 16'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 intValid", 64'(intValid), 0);
    chk("R1 fpValid", 64'(fpValid), 0);
    chk("R1 notFull", 64'(pushNotFull), 1);
    // directed pairs, units stalled while loading
    cycle(1, 0, 0, 0, mk(0, 1, 2, 3));
    cycle(1, 0, 0, 0, mk(1, 4, 5, 6));   // independent -> R7
    cycle(1, 0, 0, 0, mk(1, 7, 1, 9));   // RAW vs prior fp? chain fp after fp -> R3
    cycle(0, 0, 1, 1, 0);
    cycle(1, 0, 1, 1, mk(0, 10, 11, 12));
    cycle(1, 0, 0, 0, mk(1, 13, 10, 14)); // RAW -> R4
    cycle(1, 0, 0, 0, mk(0, 20, 21, 22));
    cycle(1, 0, 0, 0, mk(1, 21, 23, 24)); // WAR against 20<-21,22 -> R5
    cycle(1, 0, 0, 0, mk(0, 24, 25, 26)); // WAW vs fp 21? no; pair later
    cycle(1, 0, 0, 0, mk(1, 24, 27, 28)); // WAW -> R6
    for (int i = 0; i < 12; i++) cycle(0, 0, 1, 1, 0);
    // fill beyond capacity, R9
    for (int i = 0; i < DEPTH + 3; i++) cycle(1, 0, 0, 0, rnd(32));
    // head not ready, R8
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 1, 0);
    cycle(1, 1, 1, 1, rnd(32));          // flush, R10
    cycle(0, 0, 1, 1, 0);
    // random traffic with dense register reuse
    for (int i = 0; i < 4000; i++)
      cycle(($urandom % 4) != 0, ($urandom % 200) == 0, ($urandom % 4) != 0,
            ($urandom % 4) != 0, rnd(i < 3000 ? 4 : 32));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule